// File: doc/BRIEF.md
# Link Packet Transaction Assembler

This block watches a stream of fixed-size link packets, one double word per packet, and groups them into transactions. Every packet carries a start flag, an end flag, a type field and a data-error flag. A start flag seen outside a transaction opens one. The type on that opening packet is captured and held. Each later packet adds to a packet count until an end flag closes the transaction. The packet count includes the opening packet and the closing packet.

On the cycle after a transaction closes, the block raises exactly one outcome pulse. It raises commit when no packet of the transaction showed a data error, and abort when any packet did. Packets outside a transaction are stray traffic: the block drops them without touching its state.

A transaction can also end in two other ways:
- A new start flag arrives while a transaction is still open. The block aborts the open transaction and the new packet opens a fresh one.
- The transaction reaches `MAX_PKTS` packets with no end flag. The block aborts it.

The framing state machine has two states:
- `ST_IDLE` means outside a transaction.
- `ST_OPEN` means inside a transaction.

Its transitions are:
- **open**: `ST_IDLE`→`ST_OPEN` on a start packet without an end flag.
- **single**: `ST_IDLE`→`ST_IDLE` on a start packet that also ends.
- **extend**: `ST_OPEN`→`ST_OPEN` on an ordinary continuation packet.
- **restart**: `ST_OPEN`→`ST_OPEN` on a start packet.
- **close**: `ST_OPEN`→`ST_IDLE` on an end packet.
- **overrun**: `ST_OPEN`→`ST_IDLE` on the `MAX_PKTS`-th packet without an end flag.
- **drop**: `ST_IDLE`→`ST_IDLE` on a packet without a start flag.

Top module: `pkt_txn_assembler`

## Requirements
- R1: When the synchronous reset `rst` is high at a clock edge, the block leaves that edge in the following state: `in_txn_o`=0, `commit_o`=0, `abort_o`=0, `pkt_count_o`=0 and `txn_type_o`=0.
- R2: Take a valid packet with `pkt_sop`=1. After the edge that accepts it, `txn_type_o` equals that packet's `pkt_type`. The value then holds through the transaction, whatever type the later packets carry.
- R3: After the edge that accepts a valid packet with `pkt_sop`=1, `pkt_count_o` is 1. Each further accepted packet of the same transaction adds 1, including the packet that closes it. Cycles with `pkt_valid`=0 change nothing.
- R4: Take a valid packet with `pkt_eop`=1 that closes a transaction. Such a packet is either a continuation packet (`pkt_sop`=0) inside a transaction, or a packet with both flags arriving outside one. On the next cycle exactly one of `commit_o` or `abort_o` is high, and `in_txn_o` is 0.
- R5: If no packet of the transaction, including the closing one, had `pkt_err`=1, the outcome is commit. Otherwise it is abort.
- R6: A valid packet with `pkt_sop`=0 that arrives while `in_txn_o`=0 raises no outcome. It leaves `pkt_count_o`, `txn_type_o` and `in_txn_o` unchanged, whatever its end, error and type fields hold.
- R7: Take a valid packet with `pkt_sop`=1 that arrives while a transaction is open. On the next cycle `abort_o` is high for the old transaction and `in_txn_o` stays 1. `pkt_count_o` is 1 and `txn_type_o` takes the new type. Any `pkt_eop` on that packet is disregarded.
- R8: Take a transaction whose `MAX_PKTS`-th packet has `pkt_eop`=0. On the next cycle `abort_o` is high, `in_txn_o` is 0 and `pkt_count_o` equals `MAX_PKTS`. Later packets without a start flag are dropped as in R6.
- R9: `commit_o` and `abort_o` are never high together. Neither rises except on the cycle after an accepted close, restart or overrun packet. With no further packets, a pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pkt_valid | input | 1 | A packet is present this cycle |
| pkt_sop | input | 1 | Packet opens a transaction |
| pkt_eop | input | 1 | Packet closes a transaction |
| pkt_err | input | 1 | Data error detected on this packet |
| pkt_type | input | TYPE_W | Transaction type field |
| commit_o | output | 1 | One-cycle pulse: transaction completed cleanly |
| abort_o | output | 1 | One-cycle pulse: transaction discarded |
| in_txn_o | output | 1 | A transaction is open |
| txn_type_o | output | TYPE_W | Type captured from the opening packet |
| pkt_count_o | output | $clog2(MAX_PKTS+1) | Packets accepted in the current or last transaction |

## Verification
The bench sweeps every transaction length from one packet up to one past `MAX_PKTS`, and every position of a data error, including none. This exposes several classes of fault:
- A design that forgets an error seen before the end would commit instead of abort.
- A design that counts the opening packet wrongly, or tests the limit one packet late, would miss the overrun abort or would report the wrong final count.
- A design that lets packets after an overrun reopen or close a transaction would emit a spurious outcome.

Stray packets carrying end and error flags are driven between transactions. This catches a design that commits, aborts or overwrites the type on them. A start flag in the middle of a transaction, and idle gaps within one, check that the old transaction is aborted and the new type taken, and that gaps neither close nor count.

// File: rtl/pta_pkg.sv
package pta_pkg;

    // Framing state: outside or inside a transaction.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1
    } frame_state_t;

endpackage

// File: rtl/pta_framer.sv
module pta_framer
    import pta_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pkt_valid,
    input  logic pkt_sop,
    input  logic pkt_eop,
    input  logic pkt_err,
    input  logic at_last,
    output logic start_o,
    output logic step_o,
    output logic close_ok_o,
    output logic close_bad_o,
    output logic in_txn_o
);

    frame_state_t state_q;
    frame_state_t state_d;
    logic         err_seen_q;
    logic         err_seen_d;

    // State register and sticky error flag of the open transaction.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            err_seen_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            err_seen_q <= err_seen_d;
        end
    end

    // Transition decode.
    always_comb begin
        state_d     = state_q;
        err_seen_d  = err_seen_q;
        start_o     = 1'b0;
        step_o      = 1'b0;
        close_ok_o  = 1'b0;
        close_bad_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                // Packets without a start flag are dropped here.
                if (pkt_valid && pkt_sop) begin
                    start_o = 1'b1;
                    if (pkt_eop) begin
                        // single: opens and closes on one packet
                        close_ok_o  = !pkt_err;
                        close_bad_o = pkt_err;
                        err_seen_d  = 1'b0;
                    end else begin
                        // open
                        state_d    = ST_OPEN;
                        err_seen_d = pkt_err;
                    end
                end
            end
            ST_OPEN: begin
                if (pkt_valid) begin
                    if (pkt_sop) begin
                        // restart: old one aborted, new one opened
                        start_o     = 1'b1;
                        close_bad_o = 1'b1;
                        err_seen_d  = pkt_err;
                    end else if (pkt_eop) begin
                        // close
                        step_o      = 1'b1;
                        close_ok_o  = !(err_seen_q || pkt_err);
                        close_bad_o = err_seen_q || pkt_err;
                        err_seen_d  = 1'b0;
                        state_d     = ST_IDLE;
                    end else if (at_last) begin
                        // overrun: length limit without an end flag
                        step_o      = 1'b1;
                        close_bad_o = 1'b1;
                        err_seen_d  = 1'b0;
                        state_d     = ST_IDLE;
                    end else begin
                        // extend
                        step_o     = 1'b1;
                        err_seen_d = err_seen_q || pkt_err;
                    end
                end
            end
            default: begin
                state_d    = ST_IDLE;
                err_seen_d = 1'b0;
            end
        endcase
    end

    assign in_txn_o = (state_q == ST_OPEN);

endmodule

// File: rtl/pta_pkt_counter.sv
module pta_pkt_counter #(
    parameter int MAX_PKTS = 16,
    localparam int CNT_W   = $clog2(MAX_PKTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_one,
    input  logic             inc,
    output logic [CNT_W-1:0] count_o,
    output logic             at_last_o
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load_one) begin
            count_q <= CNT_W'(1);
        end else if (inc) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    // True when the packet now arriving would be the last one allowed.
    assign at_last_o = (count_q == CNT_W'(MAX_PKTS - 1));
    assign count_o   = count_q;

endmodule

// File: rtl/pta_type_latch.sv
module pta_type_latch #(
    parameter int TYPE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [TYPE_W-1:0] type_in,
    output logic [TYPE_W-1:0] type_o
);

    logic [TYPE_W-1:0] type_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            type_q <= '0;
        end else if (load) begin
            type_q <= type_in;
        end
    end

    assign type_o = type_q;

endmodule

// File: rtl/pta_outcome.sv
module pta_outcome (
    input  logic clk,
    input  logic rst,
    input  logic set_commit,
    input  logic set_abort,
    output logic commit_o,
    output logic abort_o
);

    // Output register: one pulse per closing decision.
    always_ff @(posedge clk) begin
        if (rst) begin
            commit_o <= 1'b0;
            abort_o  <= 1'b0;
        end else begin
            commit_o <= set_commit && !set_abort;
            abort_o  <= set_abort;
        end
    end

endmodule

// File: rtl/pkt_txn_assembler.sv
module pkt_txn_assembler #(
    parameter int TYPE_W   = 4,
    parameter int MAX_PKTS = 16,
    localparam int CNT_W   = $clog2(MAX_PKTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    input  logic              pkt_sop,
    input  logic              pkt_eop,
    input  logic              pkt_err,
    input  logic [TYPE_W-1:0] pkt_type,
    output logic              commit_o,
    output logic              abort_o,
    output logic              in_txn_o,
    output logic [TYPE_W-1:0] txn_type_o,
    output logic [CNT_W-1:0]  pkt_count_o
);

    logic start_w;
    logic step_w;
    logic close_ok_w;
    logic close_bad_w;
    logic at_last_w;

    pta_framer u_framer (
        .clk         (clk),
        .rst         (rst),
        .pkt_valid   (pkt_valid),
        .pkt_sop     (pkt_sop),
        .pkt_eop     (pkt_eop),
        .pkt_err     (pkt_err),
        .at_last     (at_last_w),
        .start_o     (start_w),
        .step_o      (step_w),
        .close_ok_o  (close_ok_w),
        .close_bad_o (close_bad_w),
        .in_txn_o    (in_txn_o)
    );

    pta_pkt_counter #(.MAX_PKTS(MAX_PKTS)) u_count (
        .clk       (clk),
        .rst       (rst),
        .load_one  (start_w),
        .inc       (step_w),
        .count_o   (pkt_count_o),
        .at_last_o (at_last_w)
    );

    pta_type_latch #(.TYPE_W(TYPE_W)) u_type (
        .clk     (clk),
        .rst     (rst),
        .load    (start_w),
        .type_in (pkt_type),
        .type_o  (txn_type_o)
    );

    pta_outcome u_outcome (
        .clk        (clk),
        .rst        (rst),
        .set_commit (close_ok_w),
        .set_abort  (close_bad_w),
        .commit_o   (commit_o),
        .abort_o    (abort_o)
    );

endmodule

// File: rtl/pta_checker.sv
module pta_checker #(
    parameter int TYPE_W   = 4,
    parameter int MAX_PKTS = 16,
    localparam int CNT_W   = $clog2(MAX_PKTS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              pkt_valid,
    input logic              pkt_sop,
    input logic              pkt_eop,
    input logic              pkt_err,
    input logic [TYPE_W-1:0] pkt_type,
    input logic              commit_o,
    input logic              abort_o,
    input logic              in_txn_o,
    input logic [TYPE_W-1:0] txn_type_o,
    input logic [CNT_W-1:0]  pkt_count_o
);

    AST_START_TYPE: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_sop) |=> (txn_type_o == $past(pkt_type))); // R2

    AST_END_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_sop && pkt_eop && in_txn_o) |=> ((commit_o ^ abort_o) && !in_txn_o)); // R4

    AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_sop && pkt_eop && pkt_err && in_txn_o) |=> abort_o); // R5

    AST_STRAY_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_sop && !in_txn_o) |=>
            (!commit_o && !abort_o && !in_txn_o && $stable(pkt_count_o) && $stable(txn_type_o))); // R6

    AST_RESTART_ABORTS: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_sop && in_txn_o) |=> (abort_o && in_txn_o && pkt_count_o == CNT_W'(1))); // R7

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        pkt_count_o <= CNT_W'(MAX_PKTS)); // R8

    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(commit_o && abort_o)); // R9

    AST_NO_IDLE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |=> (!commit_o && !abort_o)); // R9

endmodule

bind pkt_txn_assembler pta_checker #(.TYPE_W(TYPE_W), .MAX_PKTS(MAX_PKTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pkt_valid   (pkt_valid),
    .pkt_sop     (pkt_sop),
    .pkt_eop     (pkt_eop),
    .pkt_err     (pkt_err),
    .pkt_type    (pkt_type),
    .commit_o    (commit_o),
    .abort_o     (abort_o),
    .in_txn_o    (in_txn_o),
    .txn_type_o  (txn_type_o),
    .pkt_count_o (pkt_count_o)
);

// File: tb/pkt_txn_assembler_tb_top.sv
module pkt_txn_assembler_tb_top;

    localparam int TW   = 3;
    localparam int MAXP = 4;
    localparam int CW   = $clog2(MAXP + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pkt_valid = 1'b0;
    logic          pkt_sop = 1'b0;
    logic          pkt_eop = 1'b0;
    logic          pkt_err = 1'b0;
    logic [TW-1:0] pkt_type = '0;
    logic          commit_o;
    logic          abort_o;
    logic          in_txn_o;
    logic [TW-1:0] txn_type_o;
    logic [CW-1:0] pkt_count_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pkt_txn_assembler #(.TYPE_W(TW), .MAX_PKTS(MAXP)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .pkt_valid   (pkt_valid),
        .pkt_sop     (pkt_sop),
        .pkt_eop     (pkt_eop),
        .pkt_err     (pkt_err),
        .pkt_type    (pkt_type),
        .commit_o    (commit_o),
        .abort_o     (abort_o),
        .in_txn_o    (in_txn_o),
        .txn_type_o  (txn_type_o),
        .pkt_count_o (pkt_count_o)
    );

    task automatic send(input logic s, input logic e, input logic er, input int t);
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_sop   = s;
        pkt_eop   = e;
        pkt_err   = er;
        pkt_type  = TW'(t);
        @(posedge clk);
        #1;
        pkt_valid = 1'b0;
    endtask

    task automatic gap();
        @(negedge clk);
        pkt_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int c, input int a, input int it,
                       input int cnt, input int ty);
        n_checks++;
        if (int'(commit_o) != c || int'(abort_o) != a || int'(in_txn_o) != it ||
            int'(pkt_count_o) != cnt || int'(txn_type_o) != ty) begin
            n_fail++;
            $display("FAIL %s: got commit=%0d abort=%0d in_txn=%0d count=%0d type=%0d, expected %0d %0d %0d %0d %0d",
                     req, commit_o, abort_o, in_txn_o, pkt_count_o, txn_type_o, c, a, it, cnt, ty);
        end
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int last_cnt;
        int last_ty;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset state", 0, 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b0;

        // R6: stray packets before any transaction
        send(0, 1, 1, 5);
        chk("R6 stray end+err", 0, 0, 0, 0, 0);
        send(0, 0, 0, 6);
        chk("R6 stray plain", 0, 0, 0, 0, 0);

        // Sweep: every length 1..MAXP+1, every error position (0 = none)
        for (int len = 1; len <= MAXP + 1; len++) begin
            for (int ep = 0; ep <= len; ep++) begin
                int ty;
                ty = (len * 3 + ep) % (1 << TW);
                for (int i = 1; i <= len; i++) begin
                    bit err_sofar;
                    err_sofar = (ep != 0) && (ep <= i);
                    // later packets carry a different type that must be ignored (R2)
                    send(i == 1, i == len, i == ep, (i == 1) ? ty : ty + i);
                    if (i > MAXP) begin
                        chk("R8 R6 packet after overrun dropped", 0, 0, 0, MAXP, ty);
                    end else if (i == len) begin
                        if (err_sofar) chk("R5 R4 close with error aborts", 0, 1, 0, i, ty);
                        else           chk("R4 clean close commits", 1, 0, 0, i, ty);
                    end else if (i == MAXP) begin
                        chk("R8 overrun aborts", 0, 1, 0, MAXP, ty);
                    end else begin
                        chk("R2 R3 open transaction counts", 0, 0, 1, i, ty);
                    end
                end
                gap();
                chk("R9 pulse lasts one cycle", 0, 0, 0, (len > MAXP) ? MAXP : len, ty);
                last_cnt = (len > MAXP) ? MAXP : len;
                last_ty  = ty;
            end
        end

        // R6: stray traffic after a finished transaction keeps count and type
        send(0, 1, 0, last_ty + 1);
        chk("R6 stray end keeps state", 0, 0, 0, last_cnt, last_ty);

        // R3: idle gaps inside a transaction change nothing
        send(1, 0, 0, 2);
        chk("R3 open", 0, 0, 1, 1, 2);
        gap();
        chk("R3 gap inside transaction", 0, 0, 1, 1, 2);
        send(0, 0, 0, 7);
        chk("R3 count after gap", 0, 0, 1, 2, 2);

        // R7: restart with end flag set on the restarting packet
        send(1, 1, 0, 4);
        chk("R7 restart aborts old, opens new", 0, 1, 1, 1, 4);
        send(0, 1, 0, 1);
        chk("R7 R4 new transaction commits", 1, 0, 0, 2, 4);

        // Back-to-back single-packet transactions
        send(1, 1, 0, 3);
        chk("R4 single commit", 1, 0, 0, 1, 3);
        send(1, 1, 1, 6);
        chk("R5 single with error aborts", 0, 1, 0, 1, 6);

        // Error on the restarting packet must not leak into the new transaction's start? it does: new txn
        send(1, 0, 0, 1);
        chk("R2 open", 0, 0, 1, 1, 1);
        send(1, 0, 1, 5);
        chk("R7 restart with error", 0, 1, 1, 1, 5);
        send(0, 1, 0, 0);
        chk("R5 error on restart packet aborts new", 0, 1, 0, 2, 5);

        // R1: reset in mid-transaction
        send(1, 0, 0, 3);
        chk("R2 open before reset", 0, 0, 1, 1, 3);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 reset mid-transaction", 0, 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b0;
        send(0, 1, 0, 2);
        chk("R1 R6 end after reset dropped", 0, 0, 0, 0, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule